// File: doc/BRIEF.md
# Framebuffer Scan Address Generator

This block produces the memory address of each scan line of a packed framebuffer. The address combines the active buffer base, a pan position and the pixel size. A display timing block supplies field-start, line-start and frame-done strobes. For each strobe the generator outputs the start address of the line to fetch and a one-cycle line request for the fetch engine.

In interlaced mode the two fields start one pitch apart, and every line advances by two pitches, so each field reads alternate rows of the same buffer. In progressive mode both fields start at the same address and the step is one pitch.

The active base changes only through a single-slot flip queue. A queued base waits for the next frame-done strobe, or commits on the next cycle when the display is blanked. A second request made while one is pending is refused.

Top module: `fb_scan_addr`

## Requirements
- R1: After reset, `line_addr` is 0, the active base is 0, and `line_req`, `flip_pending`, `flip_busy` and `flip_done` are all 0.
- R2: The pan offset is `pan_y*pitch + pan_x*(bpp/8)`, where `bpp` is 8, 16, 24 or 32 and bytes per pixel is `bpp[5:3]`. One cycle after `field_start` in progressive mode, `line_req` is 1 for one cycle and `line_addr` equals base plus offset.
- R3: In progressive mode, one cycle after each `line_start`, `line_addr` has grown by `pitch` and `line_req` is 1.
- R4: In interlaced mode, a field start with `field_odd`=1 loads base plus offset. With `field_odd`=0 it loads base plus offset plus `pitch`.
- R5: In interlaced mode each `line_start` adds twice `pitch`.
- R6: `pitch` is 16 bits wide. The maximum pitch 0xFFFF gives an even-field start of +0xFFFF and a stride of 0x1FFFE, with no truncation.
- R7: When `field_start` and `line_start` are high in the same cycle, the field reload wins.
- R8: A `flip_req` with no flip pending stores `flip_base` and sets `flip_pending` on the next cycle. The active base, seen through the next field start, is unchanged until commit.
- R9: A `flip_req` while a flip is pending raises `flip_busy` for one cycle. The queued address is unchanged.
- R10: A pending flip commits on `frame_done`. On the next cycle the active base is the queued address, `flip_pending` is 0, and `flip_done` is 1 for exactly one cycle.
- R11: While `blanked` is 1, a pending flip commits on the cycle after it is accepted, with no `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pitch | input | 16 | Bytes per buffer row |
| bpp | input | 6 | Bits per pixel (8, 16, 24, 32) |
| pan_x | input | 12 | Horizontal pan in pixels |
| pan_y | input | 12 | Vertical pan in rows |
| interlace_en | input | 1 | Interlaced scan enable |
| field_start | input | 1 | Start-of-field strobe |
| field_odd | input | 1 | Field being started is odd |
| line_start | input | 1 | Next-line strobe |
| frame_done | input | 1 | Frame boundary strobe |
| blanked | input | 1 | Display is blanked |
| flip_req | input | 1 | Request to queue a new base |
| flip_base | input | 32 | Base address for the flip |
| line_addr | output | 32 | Start address of the current line |
| line_req | output | 1 | One-cycle line fetch request |
| flip_pending | output | 1 | A flip is queued |
| flip_busy | output | 1 | One-cycle refusal of a flip request |
| flip_done | output | 1 | One-cycle flip commit pulse |

## Verification
The hardest state to reach is a refused flip. It needs a request to arrive while the slot is full and the display is not blanked, and the refusal must leave no trace. The stimulus accepts one flip with `blanked` low and issues a second flip with a different address. It then commits with `frame_done` and starts a field, so the base read through `line_addr` shows which address survived. The initial base is set through the blanked fast path, which also covers that commit route.

// File: rtl/fb_scan_addr.sv
module fb_scan_addr #(
  parameter int AW = 32,
  parameter int PW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] pitch,
  input  logic [5:0]    bpp,
  input  logic [CW-1:0] pan_x,
  input  logic [CW-1:0] pan_y,
  input  logic          interlace_en,
  input  logic          field_start,
  input  logic          field_odd,
  input  logic          line_start,
  input  logic          frame_done,
  input  logic          blanked,
  input  logic          flip_req,
  input  logic [AW-1:0] flip_base,
  output logic [AW-1:0] line_addr,
  output logic          line_req,
  output logic          flip_pending,
  output logic          flip_busy,
  output logic          flip_done
);

  logic [AW-1:0] cur_base, q_base;

  wire [AW-1:0] offset     = AW'(pan_y) * AW'(pitch) + AW'(pan_x) * AW'(bpp[5:3]);
  wire [AW-1:0] stride     = interlace_en ? AW'({pitch, 1'b0}) : AW'(pitch);
  wire [AW-1:0] odd_start  = cur_base + offset;
  wire [AW-1:0] even_start = odd_start + (interlace_en ? AW'(pitch) : '0);
  wire [AW-1:0] field_addr = (!interlace_en || field_odd) ? odd_start : even_start;
  wire          commit     = flip_pending & (frame_done | blanked);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_addr    <= '0;
      line_req     <= 1'b0;
      cur_base     <= '0;
      q_base       <= '0;
      flip_pending <= 1'b0;
      flip_busy    <= 1'b0;
      flip_done    <= 1'b0;
    end else begin
      line_req  <= field_start | line_start;
      if (field_start)     line_addr <= field_addr;
      else if (line_start) line_addr <= line_addr + stride;
      flip_busy <= flip_req & flip_pending;
      flip_done <= commit;
      if (commit) begin
        cur_base     <= q_base;
        flip_pending <= 1'b0;
      end else if (flip_req && !flip_pending) begin
        q_base       <= flip_base;
        flip_pending <= 1'b1;
      end
    end
  end

  p_req_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start || line_start) |=> line_req);
  p_stride_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !field_start) |=> line_addr == $past(line_addr) + $past(stride));
  p_field_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> line_addr == $past(field_addr));
  p_base_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !flip_done |-> $stable(cur_base));
  p_busy_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flip_busy |-> (flip_pending || flip_done));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flip_done |=> !flip_done);
  p_done_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flip_done |-> !flip_pending);

endmodule

// File: tb/tb_fb_scan_addr.sv
module tb_fb_scan_addr;
  logic clk = 0, rst_n = 0;
  logic [15:0] pitch = 0;
  logic [5:0]  bpp = 6'd32;
  logic [11:0] pan_x = 0, pan_y = 0;
  logic interlace_en = 0, field_start = 0, field_odd = 0, line_start = 0;
  logic frame_done = 0, blanked = 0, flip_req = 0;
  logic [31:0] flip_base = 0;
  logic [31:0] line_addr;
  logic line_req, flip_pending, flip_busy, flip_done;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] base, exp_a;

  fb_scan_addr dut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act cyc=%0d exp <20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_field(logic odd);
    @(negedge clk); field_start = 1; field_odd = odd;
    @(negedge clk); field_start = 0;
  endtask

  task automatic do_line();
    @(negedge clk); line_start = 1;
    @(negedge clk); line_start = 0;
  endtask

  task automatic do_flip(logic [31:0] a);
    @(negedge clk); flip_req = 1; flip_base = a;
    @(negedge clk); flip_req = 0;
  endtask

  task automatic t_reset();
    chk("R1 line_addr", line_addr, 0);
    chk("R1 line_req", {31'b0, line_req}, 0);
    chk("R1 flags", {29'b0, flip_pending, flip_busy, flip_done}, 0);
    do_field(1);
    chk("R1 base zero", line_addr, 0);
  endtask

  task automatic t_blank_flip();
    blanked = 1;
    base = 32'h1000_0000;
    do_flip(base);
    chk("R11 accepted", {31'b0, flip_pending}, 1);
    @(negedge clk);
    chk("R11 done", {31'b0, flip_done}, 1);
    chk("R11 pending cleared", {31'b0, flip_pending}, 0);
    blanked = 0;
  endtask

  task automatic t_progressive();
    interlace_en = 0; pitch = 16'd2560; bpp = 6'd32; pan_x = 5; pan_y = 3;
    exp_a = base + 3*2560 + 5*4;
    do_field(0);
    chk("R2 req", {31'b0, line_req}, 1);
    chk("R2 addr", line_addr, exp_a);
    @(negedge clk);
    chk("R2 req one cycle", {31'b0, line_req}, 0);
    for (int i = 0; i < 2; i++) begin
      do_line();
      exp_a = exp_a + 2560;
      chk("R3 req", {31'b0, line_req}, 1);
      chk("R3 addr", line_addr, exp_a);
    end
    bpp = 6'd24; pan_x = 10; pan_y = 0;
    do_field(1);
    chk("R2 bpp24", line_addr, base + 30);
    bpp = 6'd16; pan_x = 7; pan_y = 1;
    do_field(1);
    chk("R2 bpp16", line_addr, base + 2560 + 14);
  endtask

  task automatic t_interlaced();
    interlace_en = 1; pitch = 16'd2560; bpp = 6'd32; pan_x = 5; pan_y = 3;
    exp_a = base + 7700;
    do_field(1);
    chk("R4 odd", line_addr, exp_a);
    do_field(0);
    chk("R4 even", line_addr, exp_a + 2560);
    do_line();
    chk("R5 stride", line_addr, exp_a + 2560 + 5120);
    pitch = 16'hFFFF; pan_x = 0; pan_y = 0;
    do_field(0);
    chk("R6 even max", line_addr, base + 32'hFFFF);
    do_line();
    chk("R6 stride max", line_addr, base + 32'hFFFF + 32'h1FFFE);
    pitch = 16'd2560; pan_x = 5; pan_y = 3;
    @(negedge clk); field_start = 1; field_odd = 1; line_start = 1;
    @(negedge clk); field_start = 0; line_start = 0;
    chk("R7 field wins", line_addr, exp_a);
  endtask

  task automatic t_flip_queue();
    interlace_en = 0; pan_x = 0; pan_y = 0;
    do_flip(32'h2000_0000);
    chk("R8 pending", {31'b0, flip_pending}, 1);
    do_field(1);
    chk("R8 base held", line_addr, base);
    do_flip(32'h3000_0000);
    chk("R9 busy", {31'b0, flip_busy}, 1);
    @(negedge clk);
    chk("R9 busy one cycle", {31'b0, flip_busy}, 0);
    chk("R9 still pending", {31'b0, flip_pending}, 1);
    @(negedge clk); frame_done = 1;
    @(negedge clk); frame_done = 0;
    chk("R10 done", {31'b0, flip_done}, 1);
    chk("R10 pending cleared", {31'b0, flip_pending}, 0);
    @(negedge clk);
    chk("R10 done one cycle", {31'b0, flip_done}, 0);
    do_field(1);
    chk("R10 new base", line_addr, 32'h2000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_pre();
    rst_n = 1;
    t_reset();
    t_blank_flip();
    t_progressive();
    t_interlaced();
    t_flip_queue();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic t_reset_pre();
    chk("R1 in reset", line_addr, 0);
  endtask
endmodule